// File: doc/BRIEF.md
# Raw-Pattern Interrupt Vector Expander

This block folds seven active-low interrupt request lines into a single active-high interrupt request for a processor. When the processor acknowledges, the block puts an 8-bit vector on the data bus. It does not encode priority. The vector is the raw pattern of the request lines with the top bit forced to one. Each combination of simultaneous requests therefore lands on its own entry in the upper half of the vector table, and the handler stored at that entry decides which request to serve first.

The request lines are asynchronous. Each one passes through a two-flop synchronizer, and both the interrupt request and the vector are formed from the synchronized copy. The acknowledge strobe is synchronous to the block clock and comes as two low pulses. The first pulse freezes the request pattern. The vector is driven during the second pulse. The bus enable is asserted only while the second pulse is low, so the bus floats at all other times.

No data moves as a stream here. The two acknowledge pulses pace the transfer on their own, so there is no valid/ready pair and no back-pressure. The processor must hold the strobe low long enough to read the bus.

Top module: `irq_pattern_vectorizer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, irq_o is 0, vec_oe_o is 0 and vec_data_o is 00h.
- R2: irq_o is 1 exactly when at least one synchronized request line is at 0.
- R3: The driven vector has bit 7 equal to 1, and bit i (i = 0..6) equal to the frozen level of request line i. Lines 0 and 1 both active with the rest idle gives FCh. Line 0 alone gives FEh, line 1 alone gives FDh, line 6 alone gives BFh and all seven active gives 80h.
- R4: vec_oe_o is 1 only while ack_n_i is 0 during the second acknowledge pulse. vec_data_o reads 00h whenever vec_oe_o is 0.
- R5: The synchronized pattern is frozen on the first clock edge that sees ack_n_i low while the block is idle. Request changes after that edge do not alter the vector until the second pulse has ended.
- R6: During the first acknowledge pulse and the gap after it, vec_oe_o stays 0.
- R7: A request change set up before clock edge k reaches irq_o only after edge k+1, which is two edges of synchronizer delay.
- R8: If every request has gone idle before the acknowledge is frozen, the vector read is FFh.
- R9: Once the second pulse ends, the next low on ack_n_i starts a new two-pulse sequence with a freshly frozen pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n_i | input | 7 | Asynchronous interrupt requests, active low, bit i is line i |
| ack_n_i | input | 1 | Interrupt acknowledge strobe, active low, two pulses per cycle |
| irq_o | output | 1 | Combined interrupt request, active high |
| vec_data_o | output | 8 | Vector for the data bus, 00h when not driving |
| vec_oe_o | output | 1 | Data bus output enable; bus floats when 0 |

## Verification
The assertions check four things on every cycle:
- irq_o follows the request inputs after exactly two edges.
- The enable never rises while the strobe is high.
- A driven vector always has its top bit set and never changes while the enable stays up.
- The bus reads zero whenever it is released.

Only the bench scenarios can show the rest. These are the two-pulse ordering, freezing at the first pulse against later request changes, the specific vector values for each combination, the spurious FFh case, and a clean restart for back-to-back acknowledges.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  // Phases of the two-pulse acknowledge handshake
  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FIRST  = 2'd1,
    ACK_GAP    = 2'd2,
    ACK_SECOND = 2'd3
  } ack_phase_t;
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // Idle level of an active-low request is 1, so every stage resets to ones
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_vec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_i,
  output logic capture_o,
  output logic drive_o
);
  ack_phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      ACK_IDLE:   if (!ack_n_i) phase_d = ACK_FIRST;
      ACK_FIRST:  if (ack_n_i)  phase_d = ACK_GAP;
      ACK_GAP:    if (!ack_n_i) phase_d = ACK_SECOND;
      ACK_SECOND: if (ack_n_i)  phase_d = ACK_IDLE;
      default:                  phase_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= ACK_IDLE;
    else        phase_q <= phase_d;
  end

  // Freeze on the edge that first sees the strobe low from idle
  assign capture_o = (phase_q == ACK_IDLE) && !ack_n_i;
  // Drive only while the second pulse is low
  assign drive_o   = !ack_n_i && ((phase_q == ACK_GAP) || (phase_q == ACK_SECOND));
endmodule

// File: rtl/irq_vec_form.sv
module irq_vec_form #(
  parameter int N_REQ = 7,
  localparam int VW   = N_REQ + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic             drive_i,
  input  logic [N_REQ-1:0] req_s_i,
  output logic [VW-1:0]    data_o,
  output logic             oe_o
);
  logic [N_REQ-1:0] frozen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         frozen_q <= '1;
    else if (capture_i) frozen_q <= req_s_i;
  end

  assign oe_o   = drive_i;
  assign data_o = drive_i ? {1'b1, frozen_q} : '0;
endmodule

// File: rtl/irq_pattern_vectorizer.sv
module irq_pattern_vectorizer #(
  parameter int N_REQ       = 7,
  parameter int SYNC_STAGES = 2,
  localparam int VW         = N_REQ + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_n_i,
  input  logic             ack_n_i,
  output logic             irq_o,
  output logic [VW-1:0]    vec_data_o,
  output logic             vec_oe_o
);
  logic [N_REQ-1:0] req_s;
  logic             capture;
  logic             drive;

  irq_req_sync #(.W(N_REQ), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_n_i),
    .q_o   (req_s)
  );

  // NAND of all synchronized active-low lines
  assign irq_o = ~&req_s;

  irq_ack_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_n_i   (ack_n_i),
    .capture_o (capture),
    .drive_o   (drive)
  );

  irq_vec_form #(.N_REQ(N_REQ)) form_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .drive_i   (drive),
    .req_s_i   (req_s),
    .data_o    (vec_data_o),
    .oe_o      (vec_oe_o)
  );
endmodule

// File: rtl/irq_pattern_vectorizer_chk.sv
module irq_pattern_vectorizer_chk #(
  parameter int N_REQ = 7,
  localparam int VW   = N_REQ + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] req_n_i,
  input logic             ack_n_i,
  input logic             irq_o,
  input logic [VW-1:0]    vec_data_o,
  input logic             vec_oe_o
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R7 and R2: two-edge latency from request pins to irq_o
  a_r7_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (irq_o == ~&$past(req_n_i, 2)));

  a_r4_no_drive_high_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n_i |-> !vec_oe_o);

  a_r4_zero_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe_o |-> (vec_data_o == '0));

  a_r3_top_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe_o |-> vec_data_o[VW-1]);

  a_r5_vector_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe_o && $past(vec_oe_o)) |-> $stable(vec_data_o));
endmodule

bind irq_pattern_vectorizer irq_pattern_vectorizer_chk #(.N_REQ(N_REQ)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_n_i    (req_n_i),
  .ack_n_i    (ack_n_i),
  .irq_o      (irq_o),
  .vec_data_o (vec_data_o),
  .vec_oe_o   (vec_oe_o)
);

// File: tb/irq_pattern_vectorizer_tb_top.sv
module irq_pattern_vectorizer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] req_n = 7'h7F;
  logic       ack_n = 1'b1;
  logic       irq;
  logic [7:0] vdata;
  logic       voe;

  int n_chk = 0;
  int n_bad = 0;
  int wd    = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_pattern_vectorizer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n_i    (req_n),
    .ack_n_i    (ack_n),
    .irq_o      (irq),
    .vec_data_o (vdata),
    .vec_oe_o   (voe)
  );

  // Behavioural reference: delayed copies of the requests and a pulse counter
  logic [6:0] m_d1 = 7'h7F, m_d2 = 7'h7F, m_frz = 7'h7F;
  int         m_pulse = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_d1 <= 7'h7F; m_d2 <= 7'h7F; m_frz <= 7'h7F; m_pulse <= 0;
    end else begin
      m_d1 <= req_n;
      m_d2 <= m_d1;
      if (m_pulse == 0 && !ack_n) begin m_frz <= m_d2; m_pulse <= 1; end
      else if (m_pulse == 1 && ack_n)  m_pulse <= 2;
      else if (m_pulse == 2 && !ack_n) m_pulse <= 3;
      else if (m_pulse == 3 && ack_n)  m_pulse <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit   e_irq, e_oe;
      logic [7:0] e_data;
      #1;
      e_irq  = ~&m_d2;
      e_oe   = !ack_n && (m_pulse == 2 || m_pulse == 3);
      e_data = e_oe ? {1'b1, m_frz} : 8'h00;
      chk(irq == e_irq, "R2 irq_o vs model", irq, e_irq);
      chk(voe == e_oe, "R4 vec_oe_o vs model", voe, e_oe);
      chk(vdata == e_data, "R3 vec_data_o vs model", vdata, e_data);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Full two-pulse acknowledge; returns the vector seen in the second pulse
  task automatic ack_seq(input string tag, output logic [7:0] v);
    @(negedge clk); ack_n = 1'b0;
    #1 chk(voe == 1'b0, {tag, " R6 first pulse silent"}, voe, 0);
    cyc(2);
    #1 chk(voe == 1'b0, {tag, " R6 first pulse held"}, voe, 0);
    @(negedge clk); ack_n = 1'b1;
    cyc(1);
    #1 chk(voe == 1'b0, {tag, " R6 gap silent"}, voe, 0);
    @(negedge clk); ack_n = 1'b0;
    #1 chk(voe == 1'b1, {tag, " R4 second pulse drives"}, voe, 1);
    v = vdata;
    cyc(1);
    @(negedge clk); ack_n = 1'b1;
    #1 chk(voe == 1'b0, {tag, " R4 release after pulse"}, voe, 0);
  endtask

  task automatic vec_case(input logic [6:0] pat, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    @(negedge clk); req_n = pat;
    cyc(4);
    ack_seq(tag, v);
    chk(v == exp, tag, v, exp);
    @(negedge clk); req_n = 7'h7F;
    cyc(4);
  endtask

  initial begin
    logic [7:0] v;
    cyc(3);
    #1;
    chk(irq == 1'b0 && voe == 1'b0 && vdata == 8'h00, "R1 in reset", {irq, voe, vdata}, 0);
    @(negedge clk); rst_n = 1'b1;
    #1 chk(irq == 1'b0 && voe == 1'b0 && vdata == 8'h00, "R1 after reset", {irq, voe, vdata}, 0);

    // R7: latency of two edges to irq_o
    @(negedge clk); req_n = 7'h7E;
    @(negedge clk); #1 chk(irq == 1'b0, "R7 not after one edge", irq, 0);
    @(negedge clk); #1 chk(irq == 1'b1, "R7 after two edges", irq, 1);
    @(negedge clk); req_n = 7'h7F;
    cyc(3);
    #1 chk(irq == 1'b0, "R2 idle drops irq", irq, 0);

    vec_case(7'h7E, 8'hFE, "R3 line0 alone");
    vec_case(7'h7D, 8'hFD, "R3 line1 alone");
    vec_case(7'h7C, 8'hFC, "R3 lines0+1");
    vec_case(7'h3F, 8'hBF, "R3 line6 alone");
    vec_case(7'h00, 8'h80, "R3 all seven");

    // R8: request withdrawn before acknowledge
    @(negedge clk); req_n = 7'h6F;
    cyc(4);
    @(negedge clk); req_n = 7'h7F;
    cyc(4);
    #1 chk(irq == 1'b0, "R8 irq dropped", irq, 0);
    ack_seq("R8", v);
    chk(v == 8'hFF, "R8 spurious vector", v, 8'hFF);

    // R5: change after freeze does not leak into the vector
    @(negedge clk); req_n = 7'h7B;
    cyc(4);
    @(negedge clk); ack_n = 1'b0;
    @(negedge clk); req_n = 7'h5F;
    cyc(3);
    @(negedge clk); ack_n = 1'b1;
    cyc(3);
    @(negedge clk); ack_n = 1'b0;
    #1 chk(vdata == 8'hFB, "R5 frozen pattern kept", vdata, 8'hFB);
    @(negedge clk); ack_n = 1'b1;

    // R9: back-to-back sequence captures the new pattern
    cyc(1);
    ack_seq("R9", v);
    chk(v == 8'hDF, "R9 fresh capture", v, 8'hDF);
    @(negedge clk); req_n = 7'h7F;
    cyc(4);

    done = 1'b1;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    #20;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule